// File: doc/BRIEF.md
# Fetch Window Generator with Two-Chunk Buffer

This block sits between an instruction cache and an instruction decoder. It requests aligned 16-byte code chunks from the cache, one per clock, and keeps at most two consecutive chunks. From these two chunks it presents a 16-byte fetch window to the decoder. The window may start at any byte address. With each chunk the cache also supplies one end-of-instruction flag per byte. The block uses these flags to find where the next window must begin. A window that ends partway through an instruction is followed by a window that starts at the first byte of that instruction.

The decoder signals `winDone` once it has consumed every instruction in the current window. Only then does the block move on to the next window. A predicted-taken jump shortens the window, so that its last valid byte is the last byte of the jump.

A redirect input changes the fetch flow. Each redirect carries a target, a cause and a description of the window that held the jump. On a redirect the block flushes both buffered chunks. The cause and the jump description then decide two things: whether the next window starts exactly at the target or at the 16-byte boundary below it, and how many extra idle cycles pass before that window is released. When the window starts at the boundary below the target, the decoder must skip the bytes that come before the target.

Top module: `fetch_window_gen`

## Requirements
- R1: The buffer holds at most two aligned chunks and gains at most one chunk per clock. `reqAddr` names the next aligned chunk that is missing, and `reqValid` is high while a slot is free. After a redirect, the first chunk requested is the target address with its low four bits cleared.
- R2: `winData` byte i is the code byte at address `winStart + i`, for i from 0 to 15.
- R3: A `chunkEnds` bit i set to 1 means that byte i of the chunk is the last byte of an instruction. After `winDone`, the next window starts one byte past the highest flagged byte that lies inside the window's valid bytes. If the last valid byte is itself flagged, the next window starts at the end of the window.
- R4: A valid window keeps the same `winStart` and stays valid until `winDone` is sampled high or a redirect arrives.
- R5: While `predValid` is high and `predLast - winStart` is below 16, `winMask` sets bits 0 through `predLast - winStart` and clears the rest. Otherwise `winMask` is all ones.
- R6: In the cycle after a redirect, `winValid` is low and `stall` is high. They stay that way until the chunks that the new window needs have loaded and the extra idle cycles have passed.
- R7: For `redirCause` = 0 (predicted jump), the group count is encoded in `redirGroups` as 0 or 1 = one group, 2 = two groups, 3 = three or more groups. The added delay and the start alignment, written as (jump window crosses a boundary, first target instruction crosses a boundary), are:
  - one group: (0,0) gives 0 and aligned down; (0,1) gives 1 and at target; (1,0) gives 1 and aligned down; (1,1) gives 2 and at target.
  - two groups: (1,0) gives 0 and aligned down; (1,1) gives 1 and at target; the other two cases give 0 and at target.
  - three or more groups: every case gives 0 and at target.
- R8: For `redirCause` = 1 (misprediction) and for 2 or 3 (interrupt, exception or serializing instruction), the window starts at the target with its low four bits cleared, and no idle cycles are added.
- R9: Count the clock edges from the edge that samples the redirect to the first cycle in which `winValid` is high. That count is 1 plus the added delay when the window is aligned, and 2 plus the added delay when it is not.
- R10: During reset `winValid` is 0, `stall` is 1, `reqValid` is 1 and `reqAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chunkValid | input | 1 | Cache returns the chunk at `reqAddr` this cycle |
| chunkData | input | 128 | Chunk bytes, byte 0 in bits 7:0 |
| chunkEnds | input | 16 | Per-byte end-of-instruction flags for the chunk |
| reqValid | output | 1 | A buffer slot is free |
| reqAddr | output | 16 | Aligned address of the chunk wanted |
| predValid | input | 1 | A predicted-taken jump is known |
| predLast | input | 16 | Address of the last byte of that jump |
| redirValid | input | 1 | Redirect strobe |
| redirTarget | input | 16 | Redirect target address |
| redirCause | input | 2 | 0 jump, 1 misprediction, 2/3 serializing event |
| redirGroups | input | 2 | Decode groups in the jump's window |
| redirCrossJump | input | 1 | The jump's window crossed a 16-byte boundary |
| redirCrossTarget | input | 1 | The first target instruction crosses a 16-byte boundary |
| winDone | input | 1 | Decoder has consumed the current window |
| winValid | output | 1 | Window outputs are valid |
| winStart | output | 16 | Window start byte address |
| winMask | output | 16 | Valid bytes of the window |
| winData | output | 128 | Window bytes |
| winEnds | output | 16 | End-of-instruction flags for the window bytes |
| stall | output | 1 | No window is available |

## Verification
A wrong buffer base or a wrong chunk order shows up at once in `winData`: the bytes no longer match the code image at `winStart`. A miscomputed cut point shows up in the `winStart` of the very next window after `winDone`. An error in the delay counter or in the table moves the first valid cycle after a redirect by one or more clocks, or shifts its start address by up to fifteen bytes. The bench counts those clocks exactly for every table entry. A flush that leaves a stale chunk behind would raise `winValid` in the cycle right after the redirect.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

  typedef enum logic [1:0] {
    CAUSE_JUMP    = 2'd0,
    CAUSE_MISPRED = 2'd1,
    CAUSE_SERIAL  = 2'd2,
    CAUSE_EVENT   = 2'd3
  } redirCause_e;

  typedef struct packed {
    logic flush;
    logic advance;
  } winStrobe_t;

  typedef struct packed {
    logic [1:0] delay;
    logic       alignDown;
  } jumpRule_t;

  // Added delay and alignment after a predicted jump (R7)
  function automatic jumpRule_t jumpRule(input logic [1:0] groups,
                                         input logic crossJump,
                                         input logic crossTarget);
    jumpRule_t r;
    r.delay     = 2'd0;
    r.alignDown = 1'b0;
    case (groups)
      2'd0, 2'd1: begin
        r.delay     = {crossJump & crossTarget, crossJump ^ crossTarget};
        r.alignDown = ~crossTarget;
      end
      2'd2: begin
        r.delay     = {1'b0, crossJump & crossTarget};
        r.alignDown = crossJump & ~crossTarget;
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fwg_datapath.sv
module fwg_datapath
  import fwg_pkg::*;
#(
  parameter int AW = 16,
  parameter int LG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        st,
  input  logic [AW-1:0]     flushStart,
  input  logic              chunkValid,
  input  logic [8*(1<<LG)-1:0] chunkData,
  input  logic [(1<<LG)-1:0]   chunkEnds,
  input  logic              predValid,
  input  logic [AW-1:0]     predLast,
  output logic              reqValid,
  output logic [AW-1:0]     reqAddr,
  output logic              covered,
  output logic [AW-1:0]     winStart,
  output logic [(1<<LG)-1:0]   winMask,
  output logic [8*(1<<LG)-1:0] winData,
  output logic [(1<<LG)-1:0]   winEnds
);
  localparam int CB = 1 << LG;
  localparam int IW = AW - LG;

  logic [IW-1:0]     baseIdx;
  logic              v0, v1;
  logic [8*CB-1:0]   data0, data1;
  logic [CB-1:0]     ends0, ends1;
  logic [AW-1:0]     startReg;
  logic [LG-1:0]     off;
  logic [16*CB-1:0]  pairData;
  logic [2*CB-1:0]   pairEnds;
  logic [AW-1:0]     predDist;
  logic              predHit;
  logic [LG-1:0]     lastIdx;
  logic [LG:0]       cutLen;
  logic [AW-1:0]     nextStart;
  logic              shiftNow, loadNow;

  assign off      = startReg[LG-1:0];
  assign covered  = v0 && ((off == '0) || v1);
  assign winStart = startReg;
  assign pairData = {data1, data0};
  assign pairEnds = {ends1, ends0};

  always_comb begin
    for (int i = 0; i < CB; i++) begin
      logic [LG:0] idx;
      idx = (LG+1)'(off) + (LG+1)'(i);
      winData[8*i +: 8] = pairData[8*idx +: 8];
      winEnds[i]        = pairEnds[idx];
    end
  end

  assign predDist = predLast - startReg;
  assign predHit  = predValid && (predDist < AW'(CB));
  assign lastIdx  = predHit ? predDist[LG-1:0] : LG'(CB-1);

  generate
    for (genvar g = 0; g < CB; g++) begin : gMask
      assign winMask[g] = (LG'(g) <= lastIdx);
    end
  endgenerate

  // cut after the highest instruction end inside the valid bytes
  always_comb begin
    cutLen = (LG+1)'(lastIdx) + (LG+1)'(1);
    for (int j = 0; j < CB; j++)
      if (winEnds[j] && (LG'(j) <= lastIdx)) cutLen = (LG+1)'(j + 1);
  end

  assign nextStart = startReg + AW'(cutLen);
  assign shiftNow  = st.advance && (nextStart[AW-1:LG] != baseIdx);
  assign reqValid  = !v1;
  assign reqAddr   = {(v0 ? baseIdx + IW'(1) : baseIdx), {LG{1'b0}}};
  assign loadNow   = chunkValid && !v1 && !st.flush && !shiftNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseIdx  <= '0;
      v0       <= 1'b0;
      v1       <= 1'b0;
      data0    <= '0;
      data1    <= '0;
      ends0    <= '0;
      ends1    <= '0;
      startReg <= '0;
    end else if (st.flush) begin
      v0       <= 1'b0;
      v1       <= 1'b0;
      baseIdx  <= flushStart[AW-1:LG];
      startReg <= flushStart;
    end else begin
      if (st.advance) startReg <= nextStart;
      if (shiftNow) begin
        baseIdx <= baseIdx + IW'(1);
        data0   <= data1;
        ends0   <= ends1;
        v0      <= v1;
        v1      <= 1'b0;
      end else if (loadNow) begin
        if (!v0) begin
          data0 <= chunkData;
          ends0 <= chunkEnds;
          v0    <= 1'b1;
        end else begin
          data1 <= chunkData;
          ends1 <= chunkEnds;
          v1    <= 1'b1;
        end
      end
    end
  end

  // R1
  one_chunk_per_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones({v0, v1}) <= $past($countones({v0, v1})) + 1));

  // R3
  advance_forward_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && !st.flush) |=> (((winStart - $past(winStart)) != '0) &&
                                  ((winStart - $past(winStart)) <= AW'(CB))));

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.flush |=> !covered);

endmodule

// File: rtl/fwg_ctrl.sv
module fwg_ctrl
  import fwg_pkg::*;
#(
  parameter int AW = 16,
  parameter int LG = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          redirValid,
  input  logic [AW-1:0] redirTarget,
  input  logic [1:0]    redirCause,
  input  logic [1:0]    redirGroups,
  input  logic          redirCrossJump,
  input  logic          redirCrossTarget,
  input  logic          winDone,
  input  logic          covered,
  output winStrobe_t    st,
  output logic [AW-1:0] flushStart,
  output logic          winValid
);
  jumpRule_t  rule;
  logic [1:0] holdCnt;

  always_comb begin
    rule = jumpRule(redirGroups, redirCrossJump, redirCrossTarget);
    if (redirCause != 2'(CAUSE_JUMP)) begin
      rule.delay     = 2'd0;
      rule.alignDown = 1'b1;
    end
  end

  assign flushStart = rule.alignDown ? {redirTarget[AW-1:LG], {LG{1'b0}}} : redirTarget;
  assign winValid   = covered && (holdCnt == 2'd0);
  assign st.flush   = redirValid;
  assign st.advance = winDone && winValid && !redirValid;

  always_ff @(posedge clk) begin
    if (!rstN)                          holdCnt <= 2'd0;
    else if (redirValid)                holdCnt <= rule.delay;
    else if (covered && holdCnt != 2'd0) holdCnt <= holdCnt - 2'd1;
  end

  // R6
  redirect_blanks_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirValid |=> !winValid);

  // R7
  wide_group_no_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && redirCause == 2'd0 && redirGroups == 2'd3) |=> (holdCnt == 2'd0));

  // R8
  serial_no_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && redirCause != 2'd0) |=> (holdCnt == 2'd0));

endmodule

// File: rtl/fetch_window_gen.sv
module fetch_window_gen
  import fwg_pkg::*;
#(
  parameter int AW = 16,
  parameter int LG = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chunkValid,
  input  logic [8*(1<<LG)-1:0] chunkData,
  input  logic [(1<<LG)-1:0]   chunkEnds,
  output logic                 reqValid,
  output logic [AW-1:0]        reqAddr,
  input  logic                 predValid,
  input  logic [AW-1:0]        predLast,
  input  logic                 redirValid,
  input  logic [AW-1:0]        redirTarget,
  input  logic [1:0]           redirCause,
  input  logic [1:0]           redirGroups,
  input  logic                 redirCrossJump,
  input  logic                 redirCrossTarget,
  input  logic                 winDone,
  output logic                 winValid,
  output logic [AW-1:0]        winStart,
  output logic [(1<<LG)-1:0]   winMask,
  output logic [8*(1<<LG)-1:0] winData,
  output logic [(1<<LG)-1:0]   winEnds,
  output logic                 stall
);
  winStrobe_t    st;
  logic [AW-1:0] flushStart;
  logic          covered;

  fwg_ctrl #(.AW(AW), .LG(LG)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .redirValid(redirValid), .redirTarget(redirTarget), .redirCause(redirCause),
    .redirGroups(redirGroups), .redirCrossJump(redirCrossJump),
    .redirCrossTarget(redirCrossTarget), .winDone(winDone), .covered(covered),
    .st(st), .flushStart(flushStart), .winValid(winValid)
  );

  fwg_datapath #(.AW(AW), .LG(LG)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .flushStart(flushStart),
    .chunkValid(chunkValid), .chunkData(chunkData), .chunkEnds(chunkEnds),
    .predValid(predValid), .predLast(predLast),
    .reqValid(reqValid), .reqAddr(reqAddr), .covered(covered),
    .winStart(winStart), .winMask(winMask), .winData(winData), .winEnds(winEnds)
  );

  assign stall = ~winValid;

  // R4
  window_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !winDone && !redirValid) |=> (winValid && $stable(winStart)));

  // R8
  serial_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && redirCause != 2'd0) |=> (winStart[LG-1:0] == '0));

endmodule

// File: tb/fetch_window_gen_bench.sv
module fetch_window_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LG = 4;
  localparam int CB = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            chunkValid = 1'b1;
  logic [8*CB-1:0] chunkData;
  logic [CB-1:0]   chunkEnds;
  logic            reqValid;
  logic [AW-1:0]   reqAddr;
  logic            predValid = 1'b0;
  logic [AW-1:0]   predLast = '0;
  logic            redirValid = 1'b0;
  logic [AW-1:0]   redirTarget = '0;
  logic [1:0]      redirCause = '0;
  logic [1:0]      redirGroups = '0;
  logic            redirCrossJump = 1'b0;
  logic            redirCrossTarget = 1'b0;
  logic            winDone = 1'b0;
  logic            winValid;
  logic [AW-1:0]   winStart;
  logic [CB-1:0]   winMask;
  logic [8*CB-1:0] winData;
  logic [CB-1:0]   winEnds;
  logic            stall;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_window_gen #(.AW(AW), .LG(LG)) u_fetch_window_gen (
    .clk(clk), .rstN(rstN), .chunkValid(chunkValid), .chunkData(chunkData),
    .chunkEnds(chunkEnds), .reqValid(reqValid), .reqAddr(reqAddr),
    .predValid(predValid), .predLast(predLast), .redirValid(redirValid),
    .redirTarget(redirTarget), .redirCause(redirCause), .redirGroups(redirGroups),
    .redirCrossJump(redirCrossJump), .redirCrossTarget(redirCrossTarget),
    .winDone(winDone), .winValid(winValid), .winStart(winStart), .winMask(winMask),
    .winData(winData), .winEnds(winEnds), .stall(stall)
  );

  // code image: a loop of known instruction lengths at 0x1000, single-byte fillers elsewhere
  function automatic logic isEnd(input logic [AW-1:0] a);
    int lens [9] = '{5, 2, 10, 6, 3, 3, 4, 1, 2};
    int p = 'h1000;
    if (a < 16'h1000 || a >= 16'h1024) return 1'b1;
    for (int k = 0; k < 9; k++) begin
      p += lens[k];
      if (int'(a) == p - 1) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [7:0] codeByte(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h5A ^ {a[11:8], 4'h0};
  endfunction

  always_comb begin
    for (int i = 0; i < CB; i++) begin
      chunkData[8*i +: 8] = codeByte(reqAddr + AW'(i));
      chunkEnds[i]        = isEnd(reqAddr + AW'(i));
    end
  end

  function automatic logic [AW-1:0] refNext(input logic [AW-1:0] s);
    int cut = CB;
    for (int j = 0; j < CB; j++) if (isEnd(s + AW'(j))) cut = j + 1;
    return s + AW'(cut);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitValid();
    for (int k = 0; k < 12; k++) begin
      if (winValid) break;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulseDone();
    @(negedge clk) winDone = 1'b1;
    @(posedge clk);
    @(negedge clk) winDone = 1'b0;
  endtask

  // drives one redirect; n counts edges after the sampling edge until winValid
  task automatic redirect(input logic [AW-1:0] tgt, input logic [1:0] cause,
                          input logic [1:0] groups, input logic cj, input logic ct,
                          output int n);
    @(negedge clk);
    redirValid = 1'b1; redirTarget = tgt; redirCause = cause;
    redirGroups = groups; redirCrossJump = cj; redirCrossTarget = ct;
    @(posedge clk);
    @(negedge clk) redirValid = 1'b0;
    chk(!winValid && stall, "R6", "blank after redirect", {winValid, stall}, 2'b01);
    chk(reqValid && reqAddr == {tgt[AW-1:4], 4'h0}, "R1", "first chunk request",
        reqAddr, {tgt[AW-1:4], 4'h0});
    n = 0;
    for (int k = 0; k < 12; k++) begin
      if (winValid) break;
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic refRule(input int g, input bit cj, input bit ct,
                         output int delay, output bit down);
    delay = 0; down = 1'b0;
    if (g <= 1) begin
      case ({cj, ct})
        2'b00: begin delay = 0; down = 1'b1; end
        2'b01: begin delay = 1; down = 1'b0; end
        2'b10: begin delay = 1; down = 1'b1; end
        default: begin delay = 2; down = 1'b0; end
      endcase
    end else if (g == 2) begin
      case ({cj, ct})
        2'b10:   begin delay = 0; down = 1'b1; end
        2'b11:   begin delay = 1; down = 1'b0; end
        default: begin delay = 0; down = 1'b0; end
      endcase
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!winValid && stall, "R10", "reset window state", {winValid, stall}, 2'b01);
    chk(reqValid && reqAddr == '0, "R10", "reset request", reqAddr, 0);
    rstN = 1'b1;
  endtask

  task automatic testStream();
    int n;
    logic [AW-1:0] expStart = 16'h1000;
    redirect(16'h1000, 2'd2, 2'd1, 1'b0, 1'b0, n);
    chk(n == 1, "R9", "aligned fill", n, 1);
    for (int w = 0; w < 3; w++) begin
      waitValid();
      chk(winValid && winStart == expStart, "R3", "window start", winStart, expStart);
      chk(winData[7:0] == codeByte(expStart) && winData[127:120] == codeByte(expStart + 16'd15),
          "R2", "window bytes", winData[7:0], codeByte(expStart));
      chk(winMask == 16'hFFFF, "R5", "full mask without prediction", winMask, 16'hFFFF);
      repeat (3) @(negedge clk);
      chk(winValid && winStart == expStart, "R4", "window held until done", winStart, expStart);
      pulseDone();
      expStart = refNext(expStart);
    end
  endtask

  task automatic testTrunc();
    int n;
    redirect(16'h1017, 2'd0, 2'd3, 1'b1, 1'b0, n);
    chk(n == 2 && winStart == 16'h1017, "R7", "three groups at target", winStart, 16'h1017);
    @(negedge clk);
    predValid = 1'b1; predLast = 16'h1022;
    #1;
    chk(winMask == 16'h0FFF, "R5", "mask ends at jump", winMask, 16'h0FFF);
    pulseDone();
    waitValid();
    chk(winValid && winStart == 16'h1022, "R3", "cut inside shortened window", winStart, 16'h1022);
    chk(winMask == 16'h0001, "R5", "one-byte mask", winMask, 16'h0001);
    predValid = 1'b0;
    #1;
    chk(winMask == 16'hFFFF, "R5", "mask restored", winMask, 16'hFFFF);
  endtask

  task automatic testTable();
    int n, delay;
    bit down;
    logic [AW-1:0] expStart;
    for (int g = 1; g <= 3; g++) begin
      for (int cj = 0; cj < 2; cj++) begin
        for (int ct = 0; ct < 2; ct++) begin
          refRule(g, cj[0], ct[0], delay, down);
          expStart = down ? 16'h1000 : 16'h1005;
          redirect(16'h1005, 2'd0, 2'(g), cj[0], ct[0], n);
          chk(winValid && winStart == expStart, "R7", "table alignment", winStart, expStart);
          chk(n == (down ? 1 : 2) + delay, "R9", "table delay", n, (down ? 1 : 2) + delay);
        end
      end
    end
  endtask

  task automatic testSerial();
    int n;
    redirect(16'h1017, 2'd1, 2'd1, 1'b1, 1'b1, n);
    chk(winValid && winStart == 16'h1010 && n == 1, "R8", "misprediction aligned",
        winStart, 16'h1010);
    redirect(16'h1021, 2'd2, 2'd1, 1'b0, 1'b1, n);
    chk(winValid && winStart == 16'h1020 && n == 1, "R8", "serializing aligned",
        winStart, 16'h1020);
    redirect(16'h100B, 2'd3, 2'd2, 1'b1, 1'b1, n);
    chk(winValid && winStart == 16'h1000 && n == 1, "R8", "event aligned",
        winStart, 16'h1000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testStream();
    testTrunc();
    testTable();
    testSerial();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule